// File: doc/BRIEF.md
# Interrupt Status Register with Halt Output

This block holds a row of interrupt status bits and reduces them to two request lines. A one-cycle hardware event pulse sets a status bit, and the bit stays set until software clears it with a write-one-to-clear access. Software reads return the stored bits as they are, with no gating applied.

Each bit has two gating selections, and both are fixed when the block is elaborated. The interrupt selection can be an active-high mask, an active-high enable, or no gating. The halt selection can be a halt mask, a halt enable, or no gating. If a bit is given both a mask and an enable, the mask is used.

The interrupt line is the OR of all the gated interrupt terms. The halt line is the OR of all the gated halt terms. Both lines are combinational, with no register stage after the stored bits. The halt line carries requests only when at least one bit has a halt mask or a halt enable. Otherwise it is tied low.

Top module: `irq_halt_reg`

## Requirements
- R1: While rst_ni is low, every status bit is 0, and irq_o and halt_o are 0.
- R2: A 1 on event_i[i] at a rising clock edge sets status bit i. The bit then stays 1 until it is cleared.
- R3: At a rising edge with clr_we_i high, each status bit whose clr_data_i bit is 1 is cleared. Bits whose clr_data_i bit is 0 keep their value. With clr_we_i low, clr_data_i has no effect.
- R4: If event_i[i] and a clear of bit i fall in the same edge, bit i ends at 1.
- R5: A bit with an interrupt mask selected (IRQ_MASK_SEL[i]=1) contributes status[i] AND NOT mask_i[i].
- R6: A bit with only an interrupt enable selected (IRQ_EN_SEL[i]=1, IRQ_MASK_SEL[i]=0) contributes status[i] AND enable_i[i].
- R7: A bit with neither interrupt selection contributes its raw status value.
- R8: If a bit has both a mask and an enable selected, only the mask form applies. This holds for both the interrupt and the halt gating.
- R9: irq_o is the OR of all interrupt terms. It is combinational: a change on a gating input shows on irq_o without waiting for a clock edge.
- R10: halt_o is the OR of the halt terms. A bit with a halt mask contributes status AND NOT halt_mask_i. A bit with only a halt enable contributes status AND halt_enable_i. Any other bit contributes its raw status. The halt terms do not depend on mask_i or enable_i.
- R11: If no bit has HALT_MASK_SEL or HALT_EN_SEL set, halt_o is always 0.
- R12: status_o always shows the raw stored bits, whatever the gating inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | N_BITS | Hardware set pulses, one per bit |
| clr_we_i | input | 1 | Software clear strobe |
| clr_data_i | input | N_BITS | Write-one-to-clear data |
| mask_i | input | N_BITS | Interrupt mask (1 blocks the bit) |
| enable_i | input | N_BITS | Interrupt enable (1 passes the bit) |
| halt_mask_i | input | N_BITS | Halt mask (1 blocks the bit) |
| halt_enable_i | input | N_BITS | Halt enable (1 passes the bit) |
| status_o | output | N_BITS | Raw stored status bits |
| irq_o | output | 1 | Gated interrupt request |
| halt_o | output | 1 | Gated halt request |

## Verification
A hardware set and a software clear of the same bit can land on the same clock edge. The bench provokes this on every stored pattern it loads: it strobes a clear of all bits while pulsing events on the chosen bits. It then checks that exactly the pulsed bits remain set.

The bench also checks the two gated outputs against values it computes arithmetically. It sweeps every stored pattern against 1024 gating combinations. A second instance with no halt gating shows that its halt line never rises.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
  // Gating variant chosen per bit at elaboration; mask takes priority over enable.
  typedef enum logic [1:0] {
    GATE_RAW    = 2'd0,
    GATE_MASK   = 2'd1,
    GATE_ENABLE = 2'd2
  } gate_kind_e;

  function automatic gate_kind_e pick_gate(input logic has_mask, input logic has_en);
    if (has_mask)    return GATE_MASK;
    else if (has_en) return GATE_ENABLE;
    else             return GATE_RAW;
  endfunction
endpackage

// File: rtl/irq_status_store.sv
module irq_status_store #(
  parameter int N_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] event_i,
  input  logic              clr_we_i,
  input  logic [N_BITS-1:0] clr_data_i,
  output logic [N_BITS-1:0] status_o
);
  logic [N_BITS-1:0] clr_hit;
  assign clr_hit = clr_we_i ? clr_data_i : '0;

  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= 1'b0;
      else if (event_i[i]) q <= 1'b1;   // set wins over clear
      else if (clr_hit[i]) q <= 1'b0;
    end
    assign status_o[i] = q;

    // R2 R4
    set_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[i] |=> status_o[i]);
    // R3
    w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_data_i[i] && !event_i[i]) |=> !status_o[i]);
    // R3
    idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!event_i[i] && !(clr_we_i && clr_data_i[i])) |=> (status_o[i] == $past(status_o[i])));
  end
endmodule

// File: rtl/irq_gate_or.sv
module irq_gate_or
  import irq_halt_pkg::*;
#(
  parameter int              N_BITS   = 4,
  parameter logic [N_BITS-1:0] MASK_SEL = '0,
  parameter logic [N_BITS-1:0] EN_SEL   = '0
) (
  input  logic [N_BITS-1:0] bits_i,
  input  logic [N_BITS-1:0] mask_i,
  input  logic [N_BITS-1:0] enable_i,
  output logic              any_o
);
  logic [N_BITS-1:0] term;

  for (genvar i = 0; i < N_BITS; i++) begin : g_term
    localparam gate_kind_e KIND = pick_gate(MASK_SEL[i], EN_SEL[i]);
    always_comb begin
      unique case (KIND)
        GATE_MASK:   term[i] = bits_i[i] & ~mask_i[i];
        GATE_ENABLE: term[i] = bits_i[i] & enable_i[i];
        default:     term[i] = bits_i[i];
      endcase
    end
  end

  assign any_o = |term;

  // R9 R10: a request needs at least one stored bit
  always_comb begin
    if (any_o) req_needs_bit_chk: assert (bits_i != '0);
  end
endmodule

// File: rtl/irq_halt_reg.sv
module irq_halt_reg #(
  parameter int                N_BITS        = 4,
  parameter logic [N_BITS-1:0] IRQ_MASK_SEL  = 4'b0101,
  parameter logic [N_BITS-1:0] IRQ_EN_SEL    = 4'b0011,
  parameter logic [N_BITS-1:0] HALT_MASK_SEL = 4'b1010,
  parameter logic [N_BITS-1:0] HALT_EN_SEL   = 4'b0110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] event_i,
  input  logic              clr_we_i,
  input  logic [N_BITS-1:0] clr_data_i,
  input  logic [N_BITS-1:0] mask_i,
  input  logic [N_BITS-1:0] enable_i,
  input  logic [N_BITS-1:0] halt_mask_i,
  input  logic [N_BITS-1:0] halt_enable_i,
  output logic [N_BITS-1:0] status_o,
  output logic              irq_o,
  output logic              halt_o
);
  localparam bit HALT_PRESENT = |(HALT_MASK_SEL | HALT_EN_SEL);

  logic [N_BITS-1:0] status_q;
  logic              irq_any, halt_any;

  irq_status_store #(.N_BITS(N_BITS)) u_store (
    .clk_i, .rst_ni, .event_i, .clr_we_i, .clr_data_i,
    .status_o(status_q)
  );

  irq_gate_or #(.N_BITS(N_BITS), .MASK_SEL(IRQ_MASK_SEL), .EN_SEL(IRQ_EN_SEL)) u_irq_gate (
    .bits_i(status_q), .mask_i(mask_i), .enable_i(enable_i), .any_o(irq_any)
  );

  irq_gate_or #(.N_BITS(N_BITS), .MASK_SEL(HALT_MASK_SEL), .EN_SEL(HALT_EN_SEL)) u_halt_gate (
    .bits_i(status_q), .mask_i(halt_mask_i), .enable_i(halt_enable_i), .any_o(halt_any)
  );

  assign status_o = status_q;
  assign irq_o    = irq_any;
  assign halt_o   = HALT_PRESENT ? halt_any : 1'b0;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (status_o == '0 && !irq_o && !halt_o));
  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != '0));
  // R11
  halt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (status_o != '0));
endmodule

// File: tb/irq_halt_reg_test.sv
module irq_halt_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [N-1:0] IM = 4'b0101, IE = 4'b0011, HM = 4'b1010, HE = 4'b0110;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] event_i = '0, clr_data_i = '0, mask_i = '0, enable_i = '0;
  logic [N-1:0] halt_mask_i = '0, halt_enable_i = '0;
  logic clr_we_i = 1'b0;
  logic [N-1:0] status_o, status_nh;
  logic irq_o, halt_o, irq_nh, halt_nh;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_halt_reg #(.N_BITS(N), .IRQ_MASK_SEL(IM), .IRQ_EN_SEL(IE),
                 .HALT_MASK_SEL(HM), .HALT_EN_SEL(HE)) uut (
    .clk_i, .rst_ni, .event_i, .clr_we_i, .clr_data_i, .mask_i, .enable_i,
    .halt_mask_i, .halt_enable_i, .status_o, .irq_o, .halt_o);

  irq_halt_reg #(.N_BITS(N), .IRQ_MASK_SEL(IM), .IRQ_EN_SEL(IE),
                 .HALT_MASK_SEL('0), .HALT_EN_SEL('0)) uut_nh (
    .clk_i, .rst_ni, .event_i, .clr_we_i, .clr_data_i, .mask_i, .enable_i,
    .halt_mask_i, .halt_enable_i, .status_o(status_nh), .irq_o(irq_nh), .halt_o(halt_nh));

  function automatic logic gated(input logic [N-1:0] s, input logic [N-1:0] ms,
                                 input logic [N-1:0] es, input logic [N-1:0] m,
                                 input logic [N-1:0] e);
    logic r = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ms[i])      r |= s[i] & ~m[i];
      else if (es[i]) r |= s[i] & e[i];
      else            r |= s[i];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, the edge latches, sample 1 time unit later
  task automatic cycle(input logic [N-1:0] ev, input logic we, input logic [N-1:0] cd);
    @(negedge clk_i);
    event_i = ev; clr_we_i = we; clr_data_i = cd;
    @(posedge clk_i); #1;
    event_i = '0; clr_we_i = 1'b0; clr_data_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] m, e, hm, he;
    // R1
    event_i = 4'hF; clr_we_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 status", status_o, '0);
    chk("R1 irq", irq_o, 0);
    chk("R1 halt", halt_o, 0);
    @(negedge clk_i); event_i = '0; rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release", status_o, '0);

    // R2: set and hold
    cycle(4'b0100, 1'b0, '0);
    chk("R2 set", status_o, 4'b0100);
    cycle('0, 1'b0, '0);
    cycle('0, 1'b0, '0);
    chk("R2 hold", status_o, 4'b0100);
    cycle(4'b1001, 1'b0, '0);
    chk("R2 accumulate", status_o, 4'b1101);
    // R3: clr_we low ignored, selective W1C
    cycle('0, 1'b0, 4'hF);
    chk("R3 no strobe ignored", status_o, 4'b1101);
    cycle('0, 1'b1, 4'b0101);
    chk("R3 selective clear", status_o, 4'b1000);
    // R4: set and clear of same bit
    cycle(4'b0010, 1'b1, 4'b1010);
    chk("R4 set wins", status_o, 4'b0010);

    // Sweep: every stored pattern x 1024 gating combos (R5-R12)
    for (int s = 0; s < 16; s++) begin
      cycle(s[N-1:0], 1'b1, 4'hF);   // R4 also: clear-all plus set
      chk("R4 load", status_o, s[N-1:0]);
      chk("R4 load nh", status_nh, s[N-1:0]);
      for (int c = 0; c < 1024; c++) begin
        m  = c[3:0];
        e  = c[7:4];
        hm = {c[1:0], c[9:8]} ^ c[7:4];
        he = {c[9:8], c[3:2]};
        mask_i = m; enable_i = e; halt_mask_i = hm; halt_enable_i = he;
        #1;
        // R5 R6 R7 R8 R9
        chk("R9 irq", irq_o, gated(s[N-1:0], IM, IE, m, e));
        // R10 R8
        chk("R10 halt", halt_o, gated(s[N-1:0], HM, HE, hm, he));
        // R11
        chk("R11 halt absent", halt_nh, 0);
        if (c[5:0] == 0) chk("R12 raw status", status_o, s[N-1:0]);
      end
    end

    // Directed single-bit corner cases
    cycle('0, 1'b1, 4'hF);
    cycle(4'b0001, 1'b0, '0);   // bit0: mask+enable -> mask wins
    mask_i = 4'b0000; enable_i = 4'b0000; #1;
    chk("R8 mask wins over enable", irq_o, 1);
    mask_i = 4'b0001; enable_i = 4'b0001; #1;
    chk("R5 masked", irq_o, 0);
    cycle('0, 1'b1, 4'hF);
    cycle(4'b0010, 1'b0, '0);   // bit1: enable only
    mask_i = 4'b0010; enable_i = 4'b0000; #1;
    chk("R6 not enabled", irq_o, 0);
    enable_i = 4'b0010; #1;
    chk("R6 enabled", irq_o, 1);
    cycle('0, 1'b1, 4'hF);
    cycle(4'b1000, 1'b0, '0);   // bit3: irq raw, halt mask
    mask_i = 4'hF; enable_i = '0; halt_mask_i = 4'b1000; #1;
    chk("R7 raw irq", irq_o, 1);
    chk("R10 halt masked", halt_o, 0);
    halt_mask_i = '0; #1;
    chk("R10 halt unmasked", halt_o, 1);
    chk("R12 status raw under gating", status_o, 4'b1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule